// File: doc/BRIEF.md
# Three-Digit Combination Lock Controller

This block is a push-button combination lock. It runs in two phases. In the store phase the user sets three 4-bit digits on a switch bank and steps through them with the buttons, which builds a 12-bit secret. In the entry phase three more digits are entered the same way. One cycle after the last digit is registered, the attempt is compared with the secret.

A match lights every status LED. A mismatch counts as a failure, and the third failure locks the controller until reset. Four buttons drive the sequence: left, right, up and down. The centre button is the asynchronous reset. Each button level is registered and reduced to a one-cycle pulse on its rising edge, so a long press still moves the sequence by exactly one step.

The outputs are a 16-bit LED vector and four 4-bit hex digit values for an external display driver. The button inputs must already be debounced. Seven-segment decoding is left to the display driver.

Top module: `combo_lock`

## Requirements
- R1: A button held high for any number of cycles advances the sequence by exactly one step. A new step needs the button low for at least one sampled cycle first.
- R2: The outputs show the new step after the second rising clock edge at which the button is seen high: one edge registers the level, the next updates the state.
- R3: In idle, left opens the store phase at digit 0. In the store phase, left captures the switch value while the digit index is below 2. At index 2, right captures the last digit, saves the 12-bit secret and returns to idle. All other buttons in the store phase are ignored, including up, down, right before index 2 and left at index 2.
- R4: The first captured digit occupies bits 11:8 of the secret or attempt, the second bits 7:4 and the third bits 3:0. Entering the stored digits in reverse order is a mismatch.
- R5: In idle, up (with left not pressed) opens the entry phase at digit 0. Digits are captured as in R3. Down at any digit of the entry phase returns to idle and takes priority over any button pressed in the same cycle.
- R6: The right press on the last attempt digit moves to a check step that lasts exactly one cycle, with LED code 8. The result state follows on the next edge.
- R7: On a match all 16 LEDs light. The lock stays open, ignoring left, right and up, until down returns it to idle.
- R8: The third failure enters lockout: LEDs all 0, all four hex digits 4'hF, and every button ignored.
- R9: A mismatch before the limit returns to entry digit 0. The failure count saturates at 3 and is cleared by a match, so two failures, a match and two more failures do not lock out.
- R10: The centre button asynchronously forces idle, clears the failure count and sets the secret to 0, without waiting for a clock edge.
- R11: The LED codes are: idle 16'h8000; store digit i gives i+1; entry digit i gives i+5; check gives 8; open gives 16'hFFFF; lockout gives 0. hex0 follows the switches in the store and entry phases and is 0 elsewhere. hex1 to hex3 are 0 outside lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_btn | input | 1 | Centre button, asynchronous active-high reset |
| btn_left | input | 1 | Capture a digit / start storing |
| btn_right | input | 1 | Capture the last digit |
| btn_up | input | 1 | Start an attempt |
| btn_down | input | 1 | Abort an attempt / leave open state |
| sw | input | 4 | Switch digit value |
| led | output | 16 | Status LEDs |
| hex0 | output | 4 | Hex digit 0 (live switch value while entering) |
| hex1 | output | 4 | Hex digit 1 |
| hex2 | output | 4 | Hex digit 2 |
| hex3 | output | 4 | Hex digit 3 |

## Verification
The bench raises a button just after a falling edge and samples the outputs at the falling edge that follows the second rising edge, which is where a press first becomes visible. The check step is sampled there as well. The match or mismatch result is sampled one edge later, and the bench confirms it stays unchanged for as long as the button is held. Reset is checked a few time units after it rises, between clock edges, to show that it acts asynchronously. Before each new press the bench leaves two low cycles, so that the edge detector can see the button go low.

// File: rtl/lock_pkg.sv
package lock_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STORE,
        ST_ENTER,
        ST_CHECK,
        ST_OPEN,
        ST_LOCK
    } lock_st_e;

    localparam int BTN_LEFT  = 0;
    localparam int BTN_RIGHT = 1;
    localparam int BTN_UP    = 2;
    localparam int BTN_DOWN  = 3;
    localparam int BTN_COUNT = 4;
    localparam int HEX_COUNT = 4;
endpackage

// File: rtl/lock_edge.sv
module lock_edge #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] pulse_o
);
    typedef struct packed {
        logic [N-1:0] lvl;
        logic [N-1:0] hist;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d.lvl  = lvl_i;
        edge_d.hist = edge_q.lvl;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) edge_q <= '0;
        else       edge_q <= edge_d;
    end

    for (genvar b = 0; b < N; b++) begin : g_pulse
        assign pulse_o[b] = edge_q.lvl[b] & ~edge_q.hist[b];
    end
endmodule

// File: rtl/lock_seq.sv
module lock_seq
    import lock_pkg::*;
#(
    parameter int DIGIT_W  = 4,
    parameter int N_DIGITS = 3,
    parameter int MAX_FAIL = 3
) (
    input  logic                                clk_i,
    input  logic                                rst_i,
    input  logic [BTN_COUNT-1:0]                pulse_i,
    input  logic [DIGIT_W-1:0]                  sw_i,
    output lock_st_e                            st_o,
    output logic [$clog2(N_DIGITS)-1:0]         idx_o,
    output logic [$clog2(MAX_FAIL+1)-1:0]       fails_o
);
    localparam int SEC_W  = DIGIT_W * N_DIGITS;
    localparam int IDX_W  = $clog2(N_DIGITS);
    localparam int FAIL_W = $clog2(MAX_FAIL + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(N_DIGITS - 1);
    localparam logic [FAIL_W-1:0] FAIL_MAX  = FAIL_W'(MAX_FAIL);
    localparam logic [FAIL_W-1:0] FAIL_EDGE = FAIL_W'(MAX_FAIL - 1);

    typedef struct packed {
        lock_st_e            st;
        logic [IDX_W-1:0]    idx;
        logic [SEC_W-1:0]    cap;
        logic [SEC_W-1:0]    key;
        logic [FAIL_W-1:0]   fails;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [SEC_W-1:0] shifted;
    logic p_left, p_right, p_up, p_down, at_last;

    assign p_left  = pulse_i[BTN_LEFT];
    assign p_right = pulse_i[BTN_RIGHT];
    assign p_up    = pulse_i[BTN_UP];
    assign p_down  = pulse_i[BTN_DOWN];
    assign shifted = {seq_q.cap[SEC_W-DIGIT_W-1:0], sw_i};
    assign at_last = (seq_q.idx == LAST_IDX);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (p_left) begin
                    seq_d.st  = ST_STORE;
                    seq_d.idx = '0;
                    seq_d.cap = '0;
                end else if (p_up) begin
                    seq_d.st  = ST_ENTER;
                    seq_d.idx = '0;
                    seq_d.cap = '0;
                end
            end
            ST_STORE: begin
                if (!at_last && p_left) begin
                    seq_d.cap = shifted;
                    seq_d.idx = seq_q.idx + IDX_W'(1);
                end else if (at_last && p_right) begin
                    seq_d.key = shifted;
                    seq_d.st  = ST_IDLE;
                end
            end
            ST_ENTER: begin
                if (p_down) begin
                    seq_d.st = ST_IDLE;
                end else if (!at_last && p_left) begin
                    seq_d.cap = shifted;
                    seq_d.idx = seq_q.idx + IDX_W'(1);
                end else if (at_last && p_right) begin
                    seq_d.cap = shifted;
                    seq_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (seq_q.cap == seq_q.key) begin
                    seq_d.st    = ST_OPEN;
                    seq_d.fails = '0;
                end else if (seq_q.fails >= FAIL_EDGE) begin
                    seq_d.st    = ST_LOCK;
                    seq_d.fails = FAIL_MAX;
                end else begin
                    seq_d.st    = ST_ENTER;
                    seq_d.fails = seq_q.fails + FAIL_W'(1);
                    seq_d.idx   = '0;
                    seq_d.cap   = '0;
                end
            end
            ST_OPEN: begin
                if (p_down) seq_d.st = ST_IDLE;
            end
            ST_LOCK: begin
                seq_d.st = ST_LOCK;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st_o    = seq_q.st;
    assign idx_o   = seq_q.idx;
    assign fails_o = seq_q.fails;
endmodule

// File: rtl/lock_view.sv
module lock_view
    import lock_pkg::*;
#(
    parameter int DIGIT_W  = 4,
    parameter int N_DIGITS = 3,
    parameter int LED_W    = 16
) (
    input  lock_st_e                              st_i,
    input  logic [$clog2(N_DIGITS)-1:0]           idx_i,
    input  logic [DIGIT_W-1:0]                    sw_i,
    output logic [LED_W-1:0]                      led_o,
    output logic [HEX_COUNT-1:0][DIGIT_W-1:0]     hex_o
);
    localparam logic [LED_W-1:0] LED_IDLE  = LED_W'(1) << (LED_W - 1);
    localparam logic [LED_W-1:0] LED_ENTRY = LED_W'(N_DIGITS + 2);
    localparam logic [LED_W-1:0] LED_CHECK = LED_W'(2 * N_DIGITS + 2);

    logic entering, locked;

    always_comb begin
        entering = 1'b0;
        locked   = 1'b0;
        led_o    = '0;
        unique case (st_i)
            ST_IDLE:  led_o = LED_IDLE;
            ST_STORE: begin
                led_o    = LED_W'(idx_i) + LED_W'(1);
                entering = 1'b1;
            end
            ST_ENTER: begin
                led_o    = LED_W'(idx_i) + LED_ENTRY;
                entering = 1'b1;
            end
            ST_CHECK: led_o = LED_CHECK;
            ST_OPEN:  led_o = '1;
            ST_LOCK:  locked = 1'b1;
            default:  led_o = '0;
        endcase
    end

    for (genvar k = 0; k < HEX_COUNT; k++) begin : g_hex
        if (k == 0) begin : g_live
            assign hex_o[k] = locked ? '1 : (entering ? sw_i : '0);
        end else begin : g_fixed
            assign hex_o[k] = locked ? '1 : '0;
        end
    end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import lock_pkg::*;
#(
    parameter int DIGIT_W  = 4,
    parameter int N_DIGITS = 3,
    parameter int MAX_FAIL = 3,
    parameter int LED_W    = 16
) (
    input  logic               clk,
    input  logic               rst_btn,
    input  logic               btn_left,
    input  logic               btn_right,
    input  logic               btn_up,
    input  logic               btn_down,
    input  logic [DIGIT_W-1:0] sw,
    output logic [LED_W-1:0]   led,
    output logic [DIGIT_W-1:0] hex0,
    output logic [DIGIT_W-1:0] hex1,
    output logic [DIGIT_W-1:0] hex2,
    output logic [DIGIT_W-1:0] hex3
);
    localparam int IDX_W  = $clog2(N_DIGITS);
    localparam int FAIL_W = $clog2(MAX_FAIL + 1);

    logic [BTN_COUNT-1:0]                btn_lvl;
    logic [BTN_COUNT-1:0]                pulse_w;
    lock_st_e                            st_w;
    logic [IDX_W-1:0]                    idx_w;
    logic [FAIL_W-1:0]                   fails_w;
    logic [HEX_COUNT-1:0][DIGIT_W-1:0]   hex_w;

    always_comb begin
        btn_lvl            = '0;
        btn_lvl[BTN_LEFT]  = btn_left;
        btn_lvl[BTN_RIGHT] = btn_right;
        btn_lvl[BTN_UP]    = btn_up;
        btn_lvl[BTN_DOWN]  = btn_down;
    end

    lock_edge #(.N(BTN_COUNT)) u_edge (
        .clk_i   (clk),
        .rst_i   (rst_btn),
        .lvl_i   (btn_lvl),
        .pulse_o (pulse_w)
    );

    lock_seq #(
        .DIGIT_W  (DIGIT_W),
        .N_DIGITS (N_DIGITS),
        .MAX_FAIL (MAX_FAIL)
    ) u_seq (
        .clk_i   (clk),
        .rst_i   (rst_btn),
        .pulse_i (pulse_w),
        .sw_i    (sw),
        .st_o    (st_w),
        .idx_o   (idx_w),
        .fails_o (fails_w)
    );

    lock_view #(
        .DIGIT_W  (DIGIT_W),
        .N_DIGITS (N_DIGITS),
        .LED_W    (LED_W)
    ) u_view (
        .st_i  (st_w),
        .idx_i (idx_w),
        .sw_i  (sw),
        .led_o (led),
        .hex_o (hex_w)
    );

    assign hex0 = hex_w[0];
    assign hex1 = hex_w[1];
    assign hex2 = hex_w[2];
    assign hex3 = hex_w[3];
endmodule

// File: rtl/lock_chk.sv
module lock_chk
    import lock_pkg::*;
#(
    parameter int DIGIT_W  = 4,
    parameter int LED_W    = 16,
    parameter int MAX_FAIL = 3
) (
    input logic                              clk_i,
    input logic                              rst_i,
    input lock_st_e                          st_i,
    input logic [BTN_COUNT-1:0]              pulse_i,
    input logic [$clog2(MAX_FAIL+1)-1:0]     fails_i,
    input logic [LED_W-1:0]                  led_i,
    input logic [DIGIT_W-1:0]                hex0_i,
    input logic [DIGIT_W-1:0]                hex1_i,
    input logic [DIGIT_W-1:0]                hex2_i,
    input logic [DIGIT_W-1:0]                hex3_i
);
    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (|pulse_i) |=> ((pulse_i & $past(pulse_i)) == '0)); // R1

    AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == ST_ENTER && pulse_i[BTN_DOWN]) |=> (st_i == ST_IDLE)); // R5

    AST_CHECK_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == ST_CHECK) |=> (st_i != ST_CHECK)); // R6

    AST_OPEN_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == ST_OPEN && !pulse_i[BTN_DOWN]) |=> (st_i == ST_OPEN)); // R7

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == ST_LOCK) |=> (st_i == ST_LOCK)); // R8

    AST_LOCK_SHOWN: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == ST_LOCK) |-> (led_i == '0 && hex0_i == '1 && hex1_i == '1
                               && hex2_i == '1 && hex3_i == '1)); // R8

    AST_FAIL_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        fails_i <= MAX_FAIL); // R9

    AST_RESET_IDLE: assert property (@(posedge clk_i)
        rst_i |-> (st_i == ST_IDLE && fails_i == '0)); // R10
endmodule

bind combo_lock lock_chk #(
    .DIGIT_W  (DIGIT_W),
    .LED_W    (LED_W),
    .MAX_FAIL (MAX_FAIL)
) u_chk (
    .clk_i   (clk),
    .rst_i   (rst_btn),
    .st_i    (st_w),
    .pulse_i (pulse_w),
    .fails_i (fails_w),
    .led_i   (led),
    .hex0_i  (hex0),
    .hex1_i  (hex1),
    .hex2_i  (hex2),
    .hex3_i  (hex3)
);

// File: tb/combo_lock_tb.sv
module combo_lock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int M_IDLE = 0, M_STORE = 1, M_ENTER = 2, M_CHECK = 3, M_OPEN = 4, M_LOCK = 5;
    localparam logic [3:0] K_L = 4'b0001, K_R = 4'b0010, K_U = 4'b0100, K_D = 4'b1000;

    logic clk = 1'b0;
    logic rst_btn = 1'b1;
    logic btn_left = 1'b0, btn_right = 1'b0, btn_up = 1'b0, btn_down = 1'b0;
    logic [3:0]  sw = 4'h0;
    logic [15:0] led;
    logic [3:0]  hex0, hex1, hex2, hex3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_st = M_IDLE, m_idx = 0, m_fail = 0;
    logic [11:0] m_cap = '0, m_key = '0;

    combo_lock u_dut (
        .clk(clk), .rst_btn(rst_btn), .btn_left(btn_left), .btn_right(btn_right),
        .btn_up(btn_up), .btn_down(btn_down), .sw(sw), .led(led),
        .hex0(hex0), .hex1(hex1), .hex2(hex2), .hex3(hex3)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] exp_led();
        case (m_st)
            M_IDLE:  return 16'h8000;
            M_STORE: return 16'(m_idx + 1);
            M_ENTER: return 16'(m_idx + 5);
            M_CHECK: return 16'd8;
            M_OPEN:  return 16'hFFFF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] exp_hex();
        if (m_st == M_LOCK) return 16'hFFFF;
        if (m_st == M_STORE || m_st == M_ENTER) return {12'h000, sw};
        return 16'h0000;
    endfunction

    task automatic check_out(input string req);
        logic [31:0] act, exp;
        act = {led, hex3, hex2, hex1, hex0};
        exp = {exp_led(), exp_hex()};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_apply(input logic [3:0] k, input logic [3:0] s);
        case (m_st)
            M_IDLE: begin
                if (k[0])      begin m_st = M_STORE; m_idx = 0; m_cap = '0; end
                else if (k[2]) begin m_st = M_ENTER; m_idx = 0; m_cap = '0; end
            end
            M_STORE: begin
                if (m_idx < 2 && k[0]) begin m_cap = {m_cap[7:0], s}; m_idx++; end
                else if (m_idx == 2 && k[1]) begin m_key = {m_cap[7:0], s}; m_st = M_IDLE; end
            end
            M_ENTER: begin
                if (k[3]) m_st = M_IDLE;
                else if (m_idx < 2 && k[0]) begin m_cap = {m_cap[7:0], s}; m_idx++; end
                else if (m_idx == 2 && k[1]) begin m_cap = {m_cap[7:0], s}; m_st = M_CHECK; end
            end
            M_OPEN: if (k[3]) m_st = M_IDLE;
            default: ;
        endcase
    endtask

    task automatic m_settle();
        if (m_st == M_CHECK) begin
            if (m_cap == m_key) begin
                m_st = M_OPEN; m_fail = 0;
            end else begin
                m_fail = (m_fail < 3) ? m_fail + 1 : 3;
                if (m_fail >= 3) m_st = M_LOCK;
                else begin m_st = M_ENTER; m_idx = 0; m_cap = '0; end
            end
        end
    endtask

    // Raise buttons after a falling edge; the step shows after the second rising edge (R2).
    task automatic press(input logic [3:0] k, input logic [3:0] s, input int hold, input string req);
        @(negedge clk);
        sw = s;
        {btn_down, btn_up, btn_right, btn_left} = k;
        m_apply(k, s);
        @(negedge clk);
        @(negedge clk);
        check_out(req);
        m_settle();
        @(negedge clk);
        check_out(req);
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            check_out(req);
        end
        {btn_down, btn_up, btn_right, btn_left} = 4'b0000;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #2 rst_btn = 1'b1;
        #1;
        m_st = M_IDLE; m_idx = 0; m_fail = 0; m_cap = '0; m_key = '0;
        check_out("R10 async reset");
        @(negedge clk);
        rst_btn = 1'b0;
        @(negedge clk);
    endtask

    task automatic attempt(input logic [11:0] v, input string req);
        press(K_L, v[11:8], 1, req);
        press(K_L, v[7:4], 1, req);
        press(K_R, v[3:0], 1, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd715));
        repeat (3) @(negedge clk);
        check_out("R10 reset state");
        check_out("R11 idle code");
        rst_btn = 1'b0;
        @(negedge clk);

        press(K_L, 4'h3, 6, "R1 held left one step");
        press(K_L, 4'hA, 1, "R3 digit 0");
        press(K_L, 4'h5, 1, "R3 digit 1");
        press(K_U, 4'h2, 1, "R3 up ignored");
        press(K_D, 4'h2, 1, "R3 down ignored");
        press(K_L, 4'h2, 1, "R3 left at last ignored");
        press(K_R, 4'hC, 1, "R3 confirm secret");

        press(K_U, 4'h0, 1, "R5 start attempt");
        attempt(12'hC5A, "R4 reversed order mismatch");
        attempt(12'hA5C, "R6 R7 match");
        press(K_U, 4'h1, 1, "R7 up ignored in open");
        press(K_L, 4'h1, 1, "R7 left ignored in open");
        press(K_D, 4'h1, 1, "R7 down leaves open");

        press(K_U, 4'h0, 1, "R5 start attempt");
        press(K_L, 4'h9, 1, "R5 digit 0");
        press(K_D | K_L, 4'h9, 1, "R5 down wins over left");
        press(K_U, 4'h0, 1, "R5 restart");
        press(K_L, 4'h1, 1, "R5 digit 0");
        press(K_L, 4'h2, 1, "R5 digit 1");
        press(K_D | K_R, 4'h3, 1, "R5 down wins over right");

        press(K_U, 4'h0, 1, "R9 start");
        attempt(12'h111, "R9 fail one");
        attempt(12'h222, "R9 fail two");
        attempt(12'hA5C, "R9 match clears count");
        press(K_D, 4'h0, 1, "R9 back to idle");
        press(K_U, 4'h0, 1, "R9 start");
        attempt(12'h333, "R9 fail one again");
        attempt(12'h444, "R9 fail two, no lockout");
        attempt(12'h555, "R8 third failure locks");
        press(K_D, 4'h0, 1, "R8 down ignored");
        press(K_U, 4'h0, 1, "R8 up ignored");
        press(K_L, 4'h0, 1, "R8 left ignored");
        press(K_R, 4'h0, 1, "R8 right ignored");

        do_reset();
        press(K_U, 4'h0, 1, "R10 start after reset");
        attempt(12'h000, "R10 secret cleared to zero");
        press(K_D, 4'h0, 1, "R10 leave open");

        for (int n = 0; n < 300; n++) begin
            logic [3:0] k;
            k = 4'b0001 << ($urandom % 4);
            if ($urandom % 8 == 0) k = k | (4'b0001 << ($urandom % 4));
            press(k, 4'($urandom % 16), 1 + ($urandom % 3), "R11 random sequence");
            if (m_st == M_LOCK && ($urandom % 2 == 0)) do_reset();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule